// File: doc/BRIEF.md
# Multicast Hash Address Filter

The block decides whether a group-addressed received frame is accepted by looking up a 64-bit programmable hash table. The six destination-address bytes enter one at a time, in the order they arrive on the wire. Each byte comes with a valid strobe, and a start marker comes with the first byte. As each byte arrives, the block folds it into a running CRC-32. After the sixth byte it reduces the CRC to a 6-bit index and reads one bit of the table. The index, a multicast flag and an accept decision then appear with a one-cycle result strobe.

The table is held in two 32-bit halves, and each half has its own simple write port. The index MSB picks the half and the five lower bits pick the bit within it. A pass-all-multicast input overrides the table and accepts every group address. Addresses whose first byte has bit 0 clear are individual addresses. For those the block still reports the index, but it flags them as not multicast and never accepts them.

Top module: `mhf_filter`

## Requirements
- R1: The index is formed from a CRC-32 over the six address bytes in wire order. The CRC register starts at all ones, uses polynomial 0x04C11DB7 in reflected form (0xEDB88320), and takes each byte least significant bit first. Index bit 5-i equals the complement of CRC register bit i, for i = 0..5.
- R2: Address bytes 1F 52 41 9C B6 AF (wire order) give index 0x2C. Address bytes A0 0A 98 00 00 45 give index 0x07.
- R3: Index bit 5 = 1 selects the high table word (`tbl_hi_wdata`) and 0 selects the low word. Index bits 4:0 give the bit position, where 0 is bit 0 and 31 is bit 31.
- R4: For a multicast address with `pass_all_mc` low, `res_accept` equals the selected table bit.
- R5: When `pass_all_mc` is high in the cycle of the sixth byte, a multicast address gives `res_accept` = 1 whatever the table holds.
- R6: `res_vld` is high for exactly the one cycle that follows the clock edge that takes in the sixth byte. `res_hash`, `res_mcast` and `res_accept` keep their values until the next result.
- R7: An address is multicast when bit 0 of its first byte is 1. Otherwise `res_mcast` = 0 and `res_accept` = 0.
- R8: A byte that has `sof` and `byte_vld` both high starts a new address and discards any partial one. Bytes after the sixth, and bytes not preceded by a start, are ignored.
- R9: After reset, both table words are zero and `res_vld`, `res_hash`, `res_mcast` and `res_accept` are all zero.
- R10: A table write in the same cycle as the sixth byte does not affect that lookup. A write in an earlier cycle does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Address byte strobe |
| sof | input | 1 | Marks the first address byte (qualified by byte_vld) |
| byte_data | input | 8 | Address byte, wire order |
| pass_all_mc | input | 1 | Accept every multicast address |
| tbl_hi_we | input | 1 | Write strobe, high table word |
| tbl_hi_wdata | input | 32 | High table word data |
| tbl_lo_we | input | 1 | Write strobe, low table word |
| tbl_lo_wdata | input | 32 | Low table word data |
| res_vld | output | 1 | Result strobe |
| res_hash | output | 6 | Computed table index |
| res_mcast | output | 1 | Address was multicast |
| res_accept | output | 1 | Accept decision |

## Verification
Two cases are hard to reach from the ports. One is a table write that lands in exactly the cycle of the sixth byte. The other is a restart that arrives in the middle of an address. The stimulus tasks can raise a write strobe on the last byte and can abort an address after a chosen number of bytes before starting again. This lets both orderings be driven on purpose. Random addresses with idle gaps, extra trailing bytes and random table contents are compared cycle by cycle against a bit-serial behavioural model, which covers every table bit in both halves.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int          CRC_W      = 32;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
    localparam int          BYTE_W     = 8;
endpackage

// File: rtl/mhf_crc_step.sv
module mhf_crc_step
    import mhf_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [DW-1:0]    data,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] chain [DW+1];

    assign chain[0] = crc_in;

    genvar g;
    generate
        for (g = 0; g < DW; g++) begin : g_bit
            logic fb;
            assign fb = chain[g][0] ^ data[g];
            assign chain[g+1] = (chain[g] >> 1) ^ (fb ? CRC_POLY_R : '0);
        end
    endgenerate

    assign crc_out = chain[DW];
endmodule

// File: rtl/mhf_hash_extract.sv
module mhf_hash_extract
    import mhf_pkg::*;
#(
    parameter int HASH_W = 6
) (
    input  logic [CRC_W-1:0]  crc,
    output logic [HASH_W-1:0] hash
);
    genvar g;
    generate
        for (g = 0; g < HASH_W; g++) begin : g_rev
            assign hash[HASH_W-1-g] = ~crc[g];
        end
    endgenerate
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
    parameter int TBL_W  = 64,
    parameter int HALF_W = TBL_W / 2,
    parameter int IDX_W  = $clog2(TBL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic [HALF_W-1:0] hi_wdata,
    input  logic              lo_we,
    input  logic [HALF_W-1:0] lo_wdata,
    input  logic [IDX_W-1:0]  idx,
    output logic              sel_bit
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (hi_we) tbl_d.hi = hi_wdata;
        if (lo_we) tbl_d.lo = lo_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // lookup reads registered words: a write in the lookup cycle is not seen
    always_comb begin
        if (idx[IDX_W-1]) sel_bit = tbl_q.hi[idx[IDX_W-2:0]];
        else              sel_bit = tbl_q.lo[idx[IDX_W-2:0]];
    end
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int TBL_W      = 64,
    parameter int HASH_W     = $clog2(TBL_W),
    parameter int HALF_W     = TBL_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              sof,
    input  logic [7:0]        byte_data,
    input  logic              pass_all_mc,
    input  logic              tbl_hi_we,
    input  logic [HALF_W-1:0] tbl_hi_wdata,
    input  logic              tbl_lo_we,
    input  logic [HALF_W-1:0] tbl_lo_wdata,
    output logic              res_vld,
    output logic [HASH_W-1:0] res_hash,
    output logic              res_mcast,
    output logic              res_accept
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [CRC_W-1:0]  crc;
        logic              mc;
        logic              vld;
        logic [HASH_W-1:0] hash;
        logic              res_mc;
        logic              acc;
    } st_t;

    st_t st_d, st_q;

    logic [CRC_W-1:0]  crc_seed;
    logic [CRC_W-1:0]  crc_next;
    logic [HASH_W-1:0] hash_next;
    logic              tbl_bit;
    logic              start;
    logic              take;

    assign start    = byte_vld && sof;
    assign take     = byte_vld && !sof && st_q.active;
    assign crc_seed = start ? CRC_PRESET : st_q.crc;

    mhf_crc_step #(.DW(BYTE_W)) i_crc (
        .crc_in  (crc_seed),
        .data    (byte_data),
        .crc_out (crc_next)
    );

    mhf_hash_extract #(.HASH_W(HASH_W)) i_hash (
        .crc  (crc_next),
        .hash (hash_next)
    );

    mhf_table #(.TBL_W(TBL_W), .HALF_W(HALF_W), .IDX_W(HASH_W)) i_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_we    (tbl_hi_we),
        .hi_wdata (tbl_hi_wdata),
        .lo_we    (tbl_lo_we),
        .lo_wdata (tbl_lo_wdata),
        .idx      (hash_next),
        .sel_bit  (tbl_bit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = CNT_W'(1);
            st_d.crc    = crc_next;
            st_d.mc     = byte_data[0];
        end else if (take) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.crc = crc_next;
            if (st_q.cnt == LAST_CNT) begin
                st_d.active = 1'b0;
                st_d.vld    = 1'b1;
                st_d.hash   = hash_next;
                st_d.res_mc = st_q.mc;
                st_d.acc    = st_q.mc && (pass_all_mc || tbl_bit);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_vld    = st_q.vld;
    assign res_hash   = st_q.hash;
    assign res_mcast  = st_q.res_mc;
    assign res_accept = st_q.acc;
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk #(
    parameter int HASH_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pass_all_mc,
    input logic              res_vld,
    input logic [HASH_W-1:0] res_hash,
    input logic              res_mcast,
    input logic              res_accept
);
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> !res_vld);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld);

    p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> ($stable(res_hash) && $stable(res_mcast) && $stable(res_accept)));

    p_unicast_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_mcast) |-> !res_accept);

    p_pass_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_mcast && $past(pass_all_mc)) |-> res_accept);
endmodule

bind mhf_filter mhf_filter_chk #(.HASH_W(HASH_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pass_all_mc (pass_all_mc),
    .res_vld     (res_vld),
    .res_hash    (res_hash),
    .res_mcast   (res_mcast),
    .res_accept  (res_accept)
);

// File: tb/test_mhf_filter.sv
module test_mhf_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic        sof = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        pass_all_mc = 1'b0;
    logic        tbl_hi_we = 1'b0;
    logic [31:0] tbl_hi_wdata = '0;
    logic        tbl_lo_we = 1'b0;
    logic [31:0] tbl_lo_wdata = '0;
    logic        res_vld;
    logic [5:0]  res_hash;
    logic        res_mcast;
    logic        res_accept;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    mhf_filter i_mhf_filter (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof),
        .byte_data(byte_data), .pass_all_mc(pass_all_mc),
        .tbl_hi_we(tbl_hi_we), .tbl_hi_wdata(tbl_hi_wdata),
        .tbl_lo_we(tbl_lo_we), .tbl_lo_wdata(tbl_lo_wdata),
        .res_vld(res_vld), .res_hash(res_hash),
        .res_mcast(res_mcast), .res_accept(res_accept)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  mq[$];
    logic        m_active = 1'b0;
    logic [31:0] m_hi = '0, m_lo = '0;
    logic        e_vld = 1'b0, e_mc = 1'b0, e_acc = 1'b0;
    logic [5:0]  e_hash = '0;

    function automatic logic [5:0] ref_hash(input logic [7:0] b [$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [5:0]  h;
        foreach (b[k]) begin
            for (int j = 0; j < 8; j++) begin
                logic fb;
                fb = c[0] ^ b[k][j];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        for (int i = 0; i < 6; i++) h[5-i] = ~c[i];
        return h;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.delete(); m_active = 0; m_hi = 0; m_lo = 0;
            e_vld = 0; e_mc = 0; e_acc = 0; e_hash = 0;
        end else begin
            e_vld = 0;
            if (byte_vld && sof) begin
                mq.delete(); mq.push_back(byte_data); m_active = 1;
            end else if (byte_vld && m_active) begin
                mq.push_back(byte_data);
                if (mq.size() == 6) begin
                    logic tb_bit;
                    m_active = 0;
                    e_vld  = 1;
                    e_hash = ref_hash(mq);
                    e_mc   = mq[0][0];
                    tb_bit = e_hash[5] ? m_hi[e_hash[4:0]] : m_lo[e_hash[4:0]];
                    e_acc  = e_mc && (pass_all_mc || tb_bit);
                end
            end
            if (tbl_hi_we) m_hi = tbl_hi_wdata;
            if (tbl_lo_we) m_lo = tbl_lo_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            compared++;
            if (res_vld !== e_vld) begin
                mismatched++;
                $display("FAIL R6 res_vld act=%0b exp=%0b", res_vld, e_vld);
            end else if (res_hash !== e_hash) begin
                mismatched++;
                $display("FAIL R1 res_hash act=%h exp=%h", res_hash, e_hash);
            end else if (res_mcast !== e_mc) begin
                mismatched++;
                $display("FAIL R7 res_mcast act=%0b exp=%0b", res_mcast, e_mc);
            end else if (res_accept !== e_acc) begin
                mismatched++;
                $display("FAIL R4 res_accept act=%0b exp=%0b", res_accept, e_acc);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_tbl(input logic [31:0] hi, input logic [31:0] lo);
        tbl_hi_we = 1; tbl_hi_wdata = hi; tbl_lo_we = 1; tbl_lo_wdata = lo;
        @(negedge clk);
        tbl_hi_we = 0; tbl_lo_we = 0;
    endtask

    // sends n bytes of addr (first byte = addr[47:40]); returns in result cycle
    task automatic send(input logic [47:0] addr, input int n, input int gap,
                        input bit wr_last, input logic [31:0] wr_hi);
        for (int i = 0; i < n; i++) begin
            byte_vld  = 1;
            sof       = (i == 0);
            byte_data = addr[47-8*i -: 8];
            if (wr_last && i == 5) begin
                tbl_hi_we = 1; tbl_hi_wdata = wr_hi;
            end
            @(negedge clk);
            byte_vld = 0; sof = 0; tbl_hi_we = 0;
            if (i < n - 1) idle(gap);
        end
    endtask

    localparam logic [47:0] EX1 = 48'h1F52_419C_B6AF;
    localparam logic [47:0] EX2 = 48'hA00A_9800_0045;

    initial begin
        idle(3);
        // R9: reset state
        chk(res_vld == 0 && res_hash == 0 && res_mcast == 0 && res_accept == 0,
            "R9 reset outputs", {res_vld, res_hash, res_mcast, res_accept}, 0);
        rst_n = 1;
        idle(2);
        // R8: bytes without a start are ignored
        byte_vld = 1; byte_data = 8'h01;
        idle(8);
        byte_vld = 0;
        chk(res_vld == 0, "R8 no start no result", res_vld, 0);

        // R2, R4, R9 zero table: example 1
        send(EX1, 6, 0, 0, 0);
        chk(res_vld == 1, "R6 strobe", res_vld, 1);
        chk(res_hash == 6'h2C, "R2 hash ex1", res_hash, 6'h2C);
        chk(res_accept == 0, "R9 table cleared R4", res_accept, 0);
        idle(1);
        chk(res_vld == 0 && res_hash == 6'h2C, "R6 pulse and hold", res_vld, 0);

        // R3: bit 12 high word accepts
        wr_tbl(32'h0000_1000, 32'h0);
        send(EX1, 6, 1, 0, 0);
        chk(res_accept == 1, "R3 high word bit12", res_accept, 1);
        wr_tbl(32'h0, 32'h0000_1000);
        send(EX1, 6, 0, 0, 0);
        chk(res_accept == 0, "R3 low word not used", res_accept, 0);

        // R2, R7: example 2 is individual
        wr_tbl('1, '1);
        send(EX2, 6, 0, 0, 0);
        chk(res_hash == 6'h07, "R2 hash ex2", res_hash, 6'h07);
        chk(res_mcast == 0 && res_accept == 0, "R7 unicast reject",
            {res_mcast, res_accept}, 0);

        // R5: pass-all overrides empty table
        wr_tbl(0, 0);
        pass_all_mc = 1;
        send(EX1, 6, 2, 0, 0);
        chk(res_accept == 1, "R5 pass all", res_accept, 1);
        pass_all_mc = 0;

        // R10: write in lookup cycle is not seen, later lookup sees it
        send(EX1, 6, 0, 1, 32'h0000_1000);
        chk(res_accept == 0, "R10 same-cycle write", res_accept, 0);
        send(EX1, 6, 0, 0, 0);
        chk(res_accept == 1, "R10 earlier write", res_accept, 1);

        // R8: restart discards partial, trailing bytes ignored
        wr_tbl(0, 0);
        send(48'h3300_0000_0000, 3, 0, 0, 0);
        send(EX1, 6, 0, 0, 0);
        chk(res_vld == 1 && res_hash == 6'h2C, "R8 restart", res_hash, 6'h2C);
        byte_vld = 1; byte_data = 8'h55;
        idle(4);
        byte_vld = 0;
        chk(res_vld == 0, "R8 trailing ignored", res_vld, 0);

        // random sweep against the model (R1, R4, R6, R7)
        for (int n = 0; n < 300; n++) begin
            logic [47:0] a;
            a = {$urandom, $urandom};
            if (n % 3 != 0) a[40] = 1'b1;
            if (n % 5 == 0) wr_tbl($urandom, $urandom);
            pass_all_mc = ($urandom % 7 == 0);
            send(a, ($urandom % 9 == 0) ? 4 : 6, $urandom % 3, 0, 0);
            if ($urandom % 4 == 0) begin
                byte_vld = 1; byte_data = $urandom;
                @(negedge clk);
                byte_vld = 0;
            end
            idle($urandom % 2);
        end
        idle(4);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule